// File: doc/BRIEF.md
# LCD Scanline Timing and Status Generator

This block derives the raster timing of a small handheld display from the system clock. Every line has a draw period followed by a horizontal blanking period. A line counter steps through the visible lines and then the vertical blanking lines, and returns to zero at the end of each frame. A status word gathers the phase flags, a sticky line-compare flag, three interrupt enables and an 8-bit compare line. Software writes the enables and the compare line, and can read the whole word back.

At each phase change the block issues one-cycle pulses: interrupt requests for hblank, vblank and line match, start strobes for hblank-triggered and vblank-triggered DMA, and a frame-complete pulse. These go to the interrupt controller and the DMA engines, which sit outside this block.

The horizontal phase is a two-state machine. `PH_DRAW` runs for `DRAW_CYC` cycles. Transition *hblank-entry* then leads to `PH_HBLANK`, which runs for `HBL_CYC` cycles. Transition *line-end* then leads back to `PH_DRAW` and advances the line counter. Line-end from line `TOTAL_LINES-1` is the *frame-wrap*, and line-end into line `VIS_LINES` is the *vblank-entry*. The defaults are 960 and 272 cycles per line, 160 visible lines and 228 lines per frame.

Top module: `lcd_scan_timer`

## Requirements
- R1: After reset the block is in the draw phase at cycle 0 of line 0. The status word reads zero and every pulse output is low.
- R2: Each line has `DRAW_CYC` cycles with status bit 1 low, followed by `HBL_CYC` cycles with status bit 1 high. Bit 1 rises at hblank-entry and falls when the next line starts.
- R3: The line counter (`line_no`) advances by one at each line-end and goes from `TOTAL_LINES-1` back to 0. `frame_done` pulses on the edge of that wrap.
- R4: Status bit 0 (vblank) is set when the line counter becomes `VIS_LINES` and cleared when the line counter wraps to 0.
- R5: At every hblank-entry, including those on vblank lines, `irq_hblank` pulses if status bit 4 is 1.
- R6: `dma_hblank_go` pulses at hblank-entry only when the current line is below `VIS_LINES`.
- R7: When the line counter becomes `VIS_LINES`, `dma_vblank_go` pulses, and `irq_vblank` pulses if status bit 3 is 1.
- R8: At every line change, including the wrap, status bit 2 is set if the new line equals status bits 15:8 and is cleared otherwise. When it is set and status bit 5 is 1, `irq_line_match` pulses. The compare uses the value held before any write on the same edge.
- R9: A write with `cfg_wr_en` loads status bits 3, 4, 5 and 15:8 from `cfg_wr_data`. Bits 0, 1 and 2 cannot be changed by a write, and bits 7:6 always read 0. An enable change takes effect from the next edge.
- R10: Every interrupt, DMA and frame output is a single-cycle pulse. Each is registered on the edge where the phase changes, so it is high during the first cycle of the new phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the status word |
| cfg_wr_data | input | 16 | Data for the writable status fields |
| status_rd | output | 16 | Status word: bit 0 vblank, bit 1 hblank, bit 2 match, bits 3/4/5 vblank/hblank/match IRQ enable, bits 15:8 compare line |
| line_no | output | 8 | Current line number |
| irq_hblank | output | 1 | Hblank interrupt request pulse |
| irq_vblank | output | 1 | Vblank interrupt request pulse |
| irq_line_match | output | 1 | Line-compare interrupt request pulse |
| dma_hblank_go | output | 1 | Hblank DMA start strobe (visible lines only) |
| dma_vblank_go | output | 1 | Vblank DMA start strobe |
| frame_done | output | 1 | Frame-complete pulse at the line wrap |

## Verification
The hardest case to reach is the frame-wrap edge with line 0 as the compare value. On that single edge the vblank flag must clear, the frame pulse must fire, and the match flag and its interrupt must be set. A second hard case is a compare-line or enable write that lands on the same edge as a line change.

Full-size frames are too long to simulate, so the bench shrinks the timing parameters. It then runs many frames with random writes, biased toward compare values of 0, `VIS_LINES` and `TOTAL_LINES-1`, and adds directed writes before the wrap. A cycle-level reference model kept in the bench is compared with every output on every cycle.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;
    localparam int LINE_W = 8;
    localparam int STAT_W = 16;

    typedef enum logic {
        PH_DRAW   = 1'b0,
        PH_HBLANK = 1'b1
    } phase_e;
endpackage

// File: rtl/lcd_phase_fsm.sv
module lcd_phase_fsm
    import lcd_timing_pkg::*;
#(
    parameter int DRAW_CYC = 960,
    parameter int HBL_CYC  = 272
) (
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase,
    output logic   hbl_enter,
    output logic   line_end
);
    localparam int MAXC = (DRAW_CYC > HBL_CYC) ? DRAW_CYC : HBL_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] DLAST = CW'(DRAW_CYC - 1);
    localparam logic [CW-1:0] HLAST = CW'(HBL_CYC - 1);

    phase_e        st_q, st_d;
    logic [CW-1:0] cyc_q, cyc_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= PH_DRAW;
            cyc_q <= '0;
        end else begin
            st_q  <= st_d;
            cyc_q <= cyc_d;
        end
    end

    // next state and transition outputs
    always_comb begin
        st_d      = st_q;
        cyc_d     = cyc_q + 1'b1;
        hbl_enter = 1'b0;
        line_end  = 1'b0;
        unique case (st_q)
            PH_DRAW: begin
                if (cyc_q == DLAST) begin
                    st_d      = PH_HBLANK;
                    cyc_d     = '0;
                    hbl_enter = 1'b1;
                end
            end
            PH_HBLANK: begin
                if (cyc_q == HLAST) begin
                    st_d     = PH_DRAW;
                    cyc_d    = '0;
                    line_end = 1'b1;
                end
            end
            default: st_d = PH_DRAW;
        endcase
    end

    assign phase = st_q;

    a_r2_draw_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PH_DRAW && cyc_q == DLAST) |=> (st_q == PH_HBLANK && cyc_q == '0));
    a_r2_hblank_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PH_HBLANK && cyc_q == HLAST) |=> (st_q == PH_DRAW && cyc_q == '0));
endmodule

// File: rtl/lcd_line_ctr.sv
module lcd_line_ctr
    import lcd_timing_pkg::*;
#(
    parameter int TOTAL_LINES = 228
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end,
    output logic [LINE_W-1:0] line,
    output logic [LINE_W-1:0] line_next,
    output logic              wrap
);
    localparam logic [LINE_W-1:0] LAST = LINE_W'(TOTAL_LINES - 1);

    logic [LINE_W-1:0] line_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            line_q <= '0;
        else if (line_end)
            line_q <= line_next;
    end

    always_comb begin
        wrap      = (line_q == LAST);
        line_next = wrap ? '0 : line_q + 1'b1;
    end

    assign line = line_q;

    a_r3_line_bound: assert property (@(posedge clk) disable iff (!rst_n)
        line_q <= LAST);
    a_r3_step_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_q) |-> $past(line_end));
endmodule

// File: rtl/lcd_stat_reg.sv
module lcd_stat_reg
    import lcd_timing_pkg::*;
#(
    parameter int VIS_LINES = 160
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hbl_enter,
    input  logic              line_end,
    input  logic              wrap,
    input  logic [LINE_W-1:0] line,
    input  logic [LINE_W-1:0] line_next,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] status,
    output logic              irq_h,
    output logic              irq_v,
    output logic              irq_m,
    output logic              dma_h,
    output logic              dma_v,
    output logic              frame
);
    localparam logic [LINE_W-1:0] VIS_L = LINE_W'(VIS_LINES);

    logic              f_vbl, f_hbl, f_match;
    logic              en_v, en_h, en_m;
    logic [LINE_W-1:0] cmp_q;
    logic              enter_vbl, hit;

    always_comb begin
        enter_vbl = line_end && (line_next == VIS_L);
        hit       = (line_next == cmp_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_vbl <= 1'b0; f_hbl <= 1'b0; f_match <= 1'b0;
            en_v  <= 1'b0; en_h  <= 1'b0; en_m    <= 1'b0;
            cmp_q <= '0;
            irq_h <= 1'b0; irq_v <= 1'b0; irq_m <= 1'b0;
            dma_h <= 1'b0; dma_v <= 1'b0; frame <= 1'b0;
        end else begin
            irq_h <= hbl_enter && en_h;
            dma_h <= hbl_enter && (line < VIS_L);
            irq_v <= enter_vbl && en_v;
            dma_v <= enter_vbl;
            frame <= line_end && wrap;
            irq_m <= line_end && hit && en_m;

            if (hbl_enter)     f_hbl <= 1'b1;
            else if (line_end) f_hbl <= 1'b0;

            if (enter_vbl)             f_vbl <= 1'b1;
            else if (line_end && wrap) f_vbl <= 1'b0;

            if (line_end) f_match <= hit;

            if (wr_en) begin
                en_v  <= wr_data[3];
                en_h  <= wr_data[4];
                en_m  <= wr_data[5];
                cmp_q <= wr_data[15:8];
            end
        end
    end

    assign status = {cmp_q, 2'b00, en_m, en_h, en_v, f_match, f_hbl, f_vbl};

    a_r5_hirq_in_hblank: assert property (@(posedge clk) disable iff (!rst_n)
        irq_h |-> f_hbl);
    a_r6_hdma_visible: assert property (@(posedge clk) disable iff (!rst_n)
        dma_h |-> (line < VIS_L));
    a_r7_vdma_at_entry: assert property (@(posedge clk) disable iff (!rst_n)
        dma_v |-> (line == VIS_L && f_vbl));
    a_r4_frame_clears_vbl: assert property (@(posedge clk) disable iff (!rst_n)
        frame |-> (line == '0 && !f_vbl));
    a_r8_match_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_m |-> f_match);
    a_r10_hirq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_h |=> !irq_h);
    a_r10_frame_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame |=> !frame);
endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
    import lcd_timing_pkg::*;
#(
    parameter int DRAW_CYC    = 960,
    parameter int HBL_CYC     = 272,
    parameter int VIS_LINES   = 160,
    parameter int TOTAL_LINES = 228
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic [15:0] cfg_wr_data,
    output logic [15:0] status_rd,
    output logic [7:0]  line_no,
    output logic        irq_hblank,
    output logic        irq_vblank,
    output logic        irq_line_match,
    output logic        dma_hblank_go,
    output logic        dma_vblank_go,
    output logic        frame_done
);
    phase_e            phase;
    logic              hbl_enter, line_end, wrap;
    logic [LINE_W-1:0] line, line_next;

    lcd_phase_fsm #(.DRAW_CYC(DRAW_CYC), .HBL_CYC(HBL_CYC)) u_phase (
        .clk(clk), .rst_n(rst_n), .phase(phase),
        .hbl_enter(hbl_enter), .line_end(line_end)
    );

    lcd_line_ctr #(.TOTAL_LINES(TOTAL_LINES)) u_line (
        .clk(clk), .rst_n(rst_n), .line_end(line_end),
        .line(line), .line_next(line_next), .wrap(wrap)
    );

    lcd_stat_reg #(.VIS_LINES(VIS_LINES)) u_stat (
        .clk(clk), .rst_n(rst_n), .hbl_enter(hbl_enter), .line_end(line_end),
        .wrap(wrap), .line(line), .line_next(line_next),
        .wr_en(cfg_wr_en), .wr_data(cfg_wr_data), .status(status_rd),
        .irq_h(irq_hblank), .irq_v(irq_vblank), .irq_m(irq_line_match),
        .dma_h(dma_hblank_go), .dma_v(dma_vblank_go), .frame(frame_done)
    );

    assign line_no = line;

    a_r2_phase_flag: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd[1] == (phase == PH_HBLANK));
endmodule

// File: tb/tb_lcd_scan_timer.sv
`timescale 1ns/1ps
module tb_lcd_scan_timer;
    localparam int D = 12, H = 5, V = 6, T = 9;

    logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] status_rd;
    logic [7:0]  line_no;
    logic        irq_h, irq_v, irq_m, dma_h, dma_v, frame;

    int n_chk = 0, n_fail = 0;
    bit chk_on = 0, done = 0;

    always #4 clk = ~clk;

    lcd_scan_timer #(.DRAW_CYC(D), .HBL_CYC(H), .VIS_LINES(V), .TOTAL_LINES(T)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr_en), .cfg_wr_data(wr_data),
        .status_rd(status_rd), .line_no(line_no), .irq_hblank(irq_h),
        .irq_vblank(irq_v), .irq_line_match(irq_m), .dma_hblank_go(dma_h),
        .dma_vblank_go(dma_v), .frame_done(frame)
    );

    // reference model, built from the requirements
    bit m_hph; int m_cyc, m_line, m_cmp;
    bit m_vbl, m_hbl, m_match, m_ev, m_eh, m_em;
    bit m_ih, m_iv, m_im, m_dh, m_dv, m_fr;
    int m_frames;

    function automatic int next_line(int l);
        return (l == T - 1) ? 0 : l + 1;
    endfunction

    function automatic logic [15:0] m_status();
        return {8'(m_cmp), 2'b00, m_em, m_eh, m_ev, m_match, m_hbl, m_vbl};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hph = 0; m_cyc = 0; m_line = 0; m_cmp = 0;
            m_vbl = 0; m_hbl = 0; m_match = 0; m_ev = 0; m_eh = 0; m_em = 0;
            m_ih = 0; m_iv = 0; m_im = 0; m_dh = 0; m_dv = 0; m_fr = 0;
        end else begin
            bit hent, lend; int nl;
            hent = !m_hph && m_cyc == D - 1;
            lend = m_hph && m_cyc == H - 1;
            nl = next_line(m_line);
            m_ih = 0; m_iv = 0; m_im = 0; m_dh = 0; m_dv = 0; m_fr = 0;
            if (hent) begin
                m_ih = m_eh; m_dh = (m_line < V); m_hbl = 1;
                m_hph = 1; m_cyc = 0;
            end else if (lend) begin
                m_hbl = 0; m_hph = 0; m_cyc = 0;
                if (nl == V) begin m_vbl = 1; m_iv = m_ev; m_dv = 1; end
                if (nl == 0) begin m_vbl = 0; m_fr = 1; m_frames++; end
                m_match = (nl == m_cmp);
                m_im = m_match && m_em;
                m_line = nl;
            end else begin
                m_cyc++;
            end
            if (wr_en) begin
                m_ev = wr_data[3]; m_eh = wr_data[4]; m_em = wr_data[5];
                m_cmp = int'(wr_data[15:8]);
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            if (n_fail <= 30)
                $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on && !done) begin
            check("R2 hblank flag", int'(status_rd[1]), int'(m_hbl));
            check("R4 vblank flag", int'(status_rd[0]), int'(m_vbl));
            check("R8 match flag", int'(status_rd[2]), int'(m_match));
            check("R9 writable fields", int'({status_rd[15:3]}), int'(m_status() >> 3));
            check("R3 line counter", int'(line_no), m_line);
            check("R3 R10 frame pulse", int'(frame), int'(m_fr));
            check("R5 R10 hblank irq", int'(irq_h), int'(m_ih));
            check("R6 R10 hblank dma", int'(dma_h), int'(m_dh));
            check("R7 R10 vblank irq", int'(irq_v), int'(m_iv));
            check("R7 R10 vblank dma", int'(dma_v), int'(m_dv));
            check("R8 R10 match irq", int'(irq_m), int'(m_im));
        end
    end

    task automatic wr(logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    function automatic logic [7:0] pick_cmp();
        unique case ($urandom % 5)
            0: return 8'd0;
            1: return 8'(V);
            2: return 8'(T - 1);
            3: return 8'(T + 3);
            default: return 8'($urandom % T);
        endcase
    endfunction

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check("R1 status", int'(status_rd), 0);
        check("R1 line", int'(line_no), 0);
        check("R1 pulses", int'({irq_h, irq_v, irq_m, dma_h, dma_v, frame}), 0);
        rst_n = 1'b1;
        chk_on = 1;
        // R9: read-only bits and bits 7:6 ignore a write of all ones
        wr(16'h00C7);
        check("R9 ro bits ignored", int'(status_rd[7:0]), int'({2'b00, 3'b000, m_match, m_hbl, m_vbl}));
        // all enables, compare on line 0: wrap edge carries frame + match
        wr({8'd0, 8'h38});
        while (m_frames < 2) @(negedge clk);
        // compare on vblank entry line
        wr({8'(V), 8'h38});
        while (m_frames < 4) @(negedge clk);
        // random phase
        for (int i = 0; i < 9000; i++) begin
            @(negedge clk);
            if ($urandom % 9 == 0) begin
                wr_en = 1'b1;
                wr_data = {pick_cmp(), 8'($urandom)};
            end else begin
                wr_en = 1'b0;
            end
        end
        @(negedge clk); wr_en = 1'b0;
        repeat (2) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule